// File: doc/BRIEF.md
# Indirect-Indexed Codec Control Register Bank

This block is the control-register front end of an audio codec. A small window of byte addresses is split into sixteen 32-bit words. Word 0 carries a pointer, and word 1 is a data port that reaches into a separate bank of thirty-two 8-bit registers. The low five bits of word 0 pick which of those registers the port sees. The other words are plain storage, with two exceptions. Word 2 is locked. Word 4 is a control word, and setting its bit 0 wipes the whole block.

Software sets the pointer first and then reads or writes word 1 to reach the codec's internal settings. Some of the indirect entries behave in special ways. Two hold fixed version codes. One mixes a single writable bit with a fixed identity pattern. One can be written but always reads back as zero. Reads come back one clock after the request, marked by a one-cycle valid strobe. The interrupt output exists for wiring only and never asserts.

Top module: `codec_regbank`

## Requirements
- R1: After the synchronous reset, every direct word reads 0, and every indirect entry reads 0 except entry 12, which reads 0x8A, and entry 25, which reads 0xA0.
- R2: The word number is the byte address shifted right by two, so address bits [1:0] are ignored. Each direct word other than 1, 2 and 4 stores and returns the full 32-bit write data.
- R3: The indirect pointer is bits [4:0] of word 0, while word 0 itself keeps all 32 bits. A write to word 1 stores bus data bits [7:0] into the pointed entry. A read of word 1 returns that entry zero-extended to 32 bits.
- R4: Indirect entry 3 accepts writes but always reads as 0 through word 1.
- R5: Writes to indirect entries 11 and 25 leave them unchanged.
- R6: A write of data D to indirect entry 12 stores (D & 0x40) | 0x8A.
- R7: Writes to direct word 2 are ignored, and word 2 always reads 0.
- R8: A write of D to word 4 stores D & 0x7F. If D bit 0 is 1, every other direct word and every indirect entry returns to its R1 value on that same clock edge, while word 4 still takes D & 0x7F.
- R9: A read request produces rd_valid high with the read data exactly one cycle later. A write, or an idle cycle, produces rd_valid low in the following cycle.
- R10: The interrupt output is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read request) |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, tied inactive |

## Verification
The bench uses several stimulus patterns to expose specific mistakes:
- It drives a pointer value with high bits set. A design that used all of word 0 as the index would reach the wrong entry, or would truncate word 0 when read back.
- It writes 0xFF and then 0x00 to entry 12. A design that dropped the forced pattern, or let bits other than bit 6 through, would read back something other than 0xCA and 0x8A.
- It fires the soft reset with the upper bits of the data set. A design that let the reset clear word 4 would lose the masked value, and one that skipped the mask would keep the upper bits. A reset that missed the indirect bank would leave old entries visible.
- Random traffic that mixes pointer moves, port accesses and control writes catches a write-only entry that leaks its stored value, version entries that accept writes, and an off-by-one in read latency.

// File: rtl/codec_regbank_pkg.sv
package codec_regbank_pkg;

  // Direct word roles
  localparam int unsigned PTR_WORD    = 0;
  localparam int unsigned PORT_WORD   = 1;
  localparam int unsigned LOCKED_WORD = 2;
  localparam int unsigned CTRL_WORD   = 4;

  // Indirect entries with special behaviour
  localparam int unsigned WO_ENTRY    = 3;
  localparam int unsigned FIXED_A     = 11;
  localparam int unsigned MIXED_ENTRY = 12;
  localparam int unsigned FIXED_B     = 25;

  localparam logic [7:0] MIXED_PATTERN = 8'h8A;
  localparam logic [7:0] MIXED_KEEP    = 8'h40;
  localparam logic [7:0] FIXED_B_CODE  = 8'hA0;

  typedef enum logic [1:0] {
    ENT_PLAIN,
    ENT_FIXED,
    ENT_MIXED
  } entry_kind_e;

  function automatic entry_kind_e kind_of(input int unsigned e);
    if (e == FIXED_A || e == FIXED_B) return ENT_FIXED;
    if (e == MIXED_ENTRY)             return ENT_MIXED;
    return ENT_PLAIN;
  endfunction

  function automatic logic [7:0] reset_code(input int unsigned e);
    if (e == MIXED_ENTRY) return MIXED_PATTERN;
    if (e == FIXED_B)     return FIXED_B_CODE;
    return 8'h00;
  endfunction

endpackage

// File: rtl/codec_direct_bank.sv
module codec_direct_bank
  import codec_regbank_pkg::*;
#(
  parameter int unsigned WORDS  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MASK_W = 7,
  localparam int unsigned WA_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [WA_W-1:0]   wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [WA_W-1:0]   rd_word,
  output logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-1:0] ptr_word
);

  logic [DATA_W-1:0] q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    assign hit = wr_en && (wr_word == WA_W'(w));
    if (w == PORT_WORD || w == LOCKED_WORD) begin : g_none
      assign q[w] = '0;
    end else if (w == CTRL_WORD) begin : g_ctrl
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst)      r <= '0;
        else if (hit) r <= DATA_W'(wr_data[MASK_W-1:0]);
      end
      assign q[w] = r;
    end else begin : g_plain
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst || clr) r <= '0;
        else if (hit)   r <= wr_data;
      end
      assign q[w] = r;
    end
  end

  assign rd_val   = q[rd_word];
  assign ptr_word = q[PTR_WORD];

  assert_ctrl_mask_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_word == WA_W'(CTRL_WORD)) |=>
      q[CTRL_WORD] == DATA_W'($past(wr_data[MASK_W-1:0])));

  assert_clear_ptr_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> ptr_word == '0);

  assert_ptr_store_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_word == WA_W'(PTR_WORD) && !clr) |=> ptr_word == $past(wr_data));

endmodule

// File: rtl/codec_indirect_bank.sv
module codec_indirect_bank
  import codec_regbank_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned ENT_W = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [ENT_W-1:0] wr_data,
  output logic [ENT_W-1:0] rd_val
);

  logic [ENT_W-1:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    localparam entry_kind_e KIND = kind_of(e);
    localparam logic [ENT_W-1:0] INIT = ENT_W'(reset_code(e));
    logic hit;
    assign hit = wr_en && (idx == IDX_W'(e));
    if (KIND == ENT_FIXED) begin : g_fixed
      assign mem[e] = INIT;
    end else if (KIND == ENT_MIXED) begin : g_mixed
      logic [ENT_W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst || clr) r <= INIT;
        else if (hit)   r <= (wr_data & ENT_W'(MIXED_KEEP)) | ENT_W'(MIXED_PATTERN);
      end
      assign mem[e] = r;
    end else begin : g_plain
      logic [ENT_W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst || clr) r <= INIT;
        else if (hit)   r <= wr_data;
      end
      assign mem[e] = r;
    end
  end

  assign rd_val = (idx == IDX_W'(WO_ENTRY)) ? '0 : mem[idx];

  assert_fixed_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (idx == IDX_W'(FIXED_A) || idx == IDX_W'(FIXED_B))) |=>
      ($stable(mem[FIXED_A]) && $stable(mem[FIXED_B])));

  assert_mixed_write_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IDX_W'(MIXED_ENTRY) && !clr) |=>
      mem[MIXED_ENTRY] == (($past(wr_data) & ENT_W'(MIXED_KEEP)) | ENT_W'(MIXED_PATTERN)));

  assert_clear_mixed_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> mem[MIXED_ENTRY] == ENT_W'(MIXED_PATTERN));

endmodule

// File: rtl/codec_regbank.sv
module codec_regbank
  import codec_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ENT_W     = 8,
  parameter int unsigned IND_DEPTH = 32,
  parameter int unsigned CTRL_W    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  localparam int unsigned WA_W  = ADDR_W - 2;
  localparam int unsigned WORDS = 1 << WA_W;
  localparam int unsigned IDX_W = $clog2(IND_DEPTH);

  logic [WA_W-1:0]   word;
  logic              wr_en, rd_en, soft_clr, port_wr, port_sel;
  logic [DATA_W-1:0] dir_val, ptr_word;
  logic [ENT_W-1:0]  ind_val;
  logic [IDX_W-1:0]  idx;

  assign word     = bus_addr[ADDR_W-1:2];
  assign wr_en    = bus_req && bus_we && (word != WA_W'(LOCKED_WORD));
  assign rd_en    = bus_req && !bus_we;
  assign port_sel = (word == WA_W'(PORT_WORD));
  assign port_wr  = wr_en && port_sel;
  assign soft_clr = wr_en && (word == WA_W'(CTRL_WORD)) && bus_wdata[0];
  assign idx      = ptr_word[IDX_W-1:0];

  codec_direct_bank #(
    .WORDS (WORDS),
    .DATA_W(DATA_W),
    .MASK_W(CTRL_W)
  ) u_direct (
    .clk     (clk),
    .rst     (rst),
    .clr     (soft_clr),
    .wr_en   (wr_en),
    .wr_word (word),
    .wr_data (bus_wdata),
    .rd_word (word),
    .rd_val  (dir_val),
    .ptr_word(ptr_word)
  );

  codec_indirect_bank #(
    .DEPTH(IND_DEPTH),
    .ENT_W(ENT_W)
  ) u_indirect (
    .clk    (clk),
    .rst    (rst),
    .clr    (soft_clr),
    .wr_en  (port_wr),
    .idx    (idx),
    .wr_data(bus_wdata[ENT_W-1:0]),
    .rd_val (ind_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= port_sel ? DATA_W'(ind_val) : dir_val;
    end
  end

  assign irq = 1'b0;

  assert_rd_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_no_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  assert_port_zext_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && port_sel) |=> rd_data[DATA_W-1:ENT_W] == '0);

  assert_wo_read_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && port_sel && idx == IDX_W'(WO_ENTRY)) |=> rd_data == '0);

  assert_locked_read_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && word == WA_W'(LOCKED_WORD)) |=> rd_data == '0);

endmodule

// File: tb/codec_regbank_bench.sv
`timescale 1ns/1ps
module codec_regbank_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  logic [31:0] dm [16];
  logic [7:0]  im [32];

  always #2 clk = ~clk;

  codec_regbank u_codec_regbank (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  function automatic void m_reset();
    for (int i = 0; i < 16; i++) dm[i] = '0;
    for (int i = 0; i < 32; i++) im[i] = '0;
    im[12] = 8'h8A;
    im[25] = 8'hA0;
  endfunction

  function automatic void m_write(input int w, input logic [31:0] d);
    int ix;
    ix = int'(dm[0][4:0]);
    case (w)
      1: begin
        if (ix == 12)                 im[12] = (d[7:0] & 8'h40) | 8'h8A;
        else if (ix != 11 && ix != 25) im[ix] = d[7:0];
      end
      2: ;
      4: begin
        if (d[0]) m_reset();
        dm[4] = d & 32'h7F;
      end
      default: dm[w] = d;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input int w);
    int ix;
    ix = int'(dm[0][4:0]);
    if (w == 1) return (ix == 3) ? 32'h0 : {24'h0, im[ix]};
    return dm[w];
  endfunction

  function automatic string tag_of(input int w);
    int ix;
    ix = int'(dm[0][4:0]);
    if (w == 1) begin
      if (ix == 3) return "R4";
      if (ix == 11 || ix == 25) return "R5";
      if (ix == 12) return "R6";
      return "R3";
    end
    if (w == 2) return "R7";
    if (w == 4) return "R8";
    return "R2";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int w, input logic [31:0] d, input logic [1:0] lo = 2'b00);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = {w[3:0], lo}; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    m_write(w, d);
  endtask

  task automatic rd(input int w, input string tag, input logic [1:0] lo = 2'b00);
    logic [31:0] exp;
    exp = m_read(w);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = {w[3:0], lo};
    @(negedge clk);
    bus_req = 1'b0;
    chk(rd_valid === 1'b1, "R9", {31'h0, rd_valid}, 32'h1);
    chk(rd_data === exp, tag, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset values of every direct word and every indirect entry
    for (int w = 0; w < 16; w++) rd(w, "R1");
    for (int e = 0; e < 32; e++) begin
      wr(0, e);
      rd(1, (e == 12 || e == 25) ? "R1" : "R1");
    end
    wr(0, 0);

    // R10: interrupt idle
    chk(irq === 1'b0, "R10", {31'h0, irq}, 32'h0);

    // R9: write gives no strobe, idle cycle gives none
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = {4'd5, 2'b00}; bus_wdata = 32'hCAFE_F00D;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; m_write(5, 32'hCAFE_F00D);
    chk(rd_valid === 1'b0, "R9", {31'h0, rd_valid}, 32'h0);
    rd(5, "R2");
    @(negedge clk);
    chk(rd_valid === 1'b0, "R9", {31'h0, rd_valid}, 32'h0);

    // R2: low address bits ignored, full word stored
    wr(9, 32'hDEAD_BEEF, 2'b11);
    rd(9, "R2", 2'b01);
    chk(m_read(9) == 32'hDEAD_BEEF, "R2", m_read(9), 32'hDEAD_BEEF);

    // R3: pointer uses low five bits, word 0 keeps all bits
    wr(0, 32'hFFFF_FFE5);
    rd(0, "R3");
    wr(1, 32'h1234_5677);
    rd(1, "R3");
    chk(im[5] == 8'h77, "R3", {24'h0, im[5]}, 32'h77);

    // R4: write-only entry reads zero
    wr(0, 3); wr(1, 32'h55); rd(1, "R4");

    // R5: fixed entries ignore writes
    wr(0, 11); wr(1, 32'hFF); rd(1, "R5");
    wr(0, 25); wr(1, 32'h12); rd(1, "R5");

    // R6: mixed entry
    wr(0, 12); wr(1, 32'hFF); rd(1, "R6");
    chk(m_read(1) == 32'hCA, "R6", m_read(1), 32'hCA);
    wr(1, 32'h00); rd(1, "R6");

    // R7: locked word
    wr(2, 32'hFFFF_FFFF); rd(2, "R7");

    // R8: control word without and with soft reset
    wr(4, 32'hFFFF_FFFE); rd(4, "R8"); rd(9, "R8");
    wr(0, 7); wr(1, 32'h99); wr(3, 32'h1234);
    wr(4, 32'hFFFF_FF81);
    rd(4, "R8"); rd(3, "R8"); rd(0, "R8"); rd(9, "R8");
    wr(0, 7);  rd(1, "R8");
    wr(0, 12); rd(1, "R8");

    // Random traffic
    for (int n = 0; n < 1500; n++) begin
      int r, w;
      logic [31:0] d;
      r = int'($urandom % 100);
      d = $urandom;
      if (r < 20) wr(0, {d[31:5], 5'(($urandom % 32))});
      else if (r < 40) wr(1, d);
      else if (r < 65) rd(1, tag_of(1));
      else if (r < 80) begin
        w = int'($urandom % 16);
        if (w == 4 && ($urandom % 8) != 0) d[0] = 1'b0;
        wr(w, d, 2'($urandom));
      end else begin
        w = int'($urandom % 16);
        rd(w, tag_of(w), 2'($urandom));
      end
    end

    // R1: hard reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_reset();
    rd(0, "R1"); rd(7, "R1"); rd(4, "R1");
    wr(0, 25); rd(1, "R1");
    chk(irq === 1'b0, "R10", {31'h0, irq}, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule